// File: doc/BRIEF.md
# Competing Two-Rule Step Engine

This block advances a pair of rival rewriting rules by one maximally parallel transition per clock. Both rules consume the shared object a. The first rule also takes one c and gives back one c-prime. The second rule takes one c-prime and gives back one c. The engine keeps the three populations in registers. On every enabled step it draws a pseudo-random fraction from an internal shift-register generator and uses it to divide a into two shares, one per rule. Each rule then fires as often as its partner population allows. The a objects that one rule cannot use are offered to the other rule in the same cycle. As a result the step always consumes as many a objects as the combined partner supply permits, whatever the random split.

A host loads the three starting populations and a seed with one load pulse. It then raises the step enable for as many cycles as it wants transitions. The step enable may stay high; every clock edge that samples it performs one complete transition. The firing counts of the most recent step and a halted flag are on the outputs. The flag shows that no rule can fire any more.

Top module: `rivalry_step`

## Requirements
- R1: While reset is low, every population register and both firing outputs are cleared to zero, the generator register holds 1, and halted_o reads 1.
- R2: An edge that samples load_i high copies init_a_i, init_c_i and init_cp_i into the population registers, clears fire1_o and fire2_o, and loads the generator with seed_i, or with 1 when seed_i is zero. Load takes priority over a step in the same cycle.
- R3: A step uses the current generator value L. The share of the first rule is a1 = floor(a*L / 2^16) and the share of the second is a2 = a - a1. After the step, L shifts one place toward its MSB, and its new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R4: The surplus of the first rule is d1 = max(0, a1 - c), and the surplus of the second is d2 = max(0, a2 - c').
- R5: The first rule fires n1 = min(c, a1 + d2) times and the second fires n2 = min(c', a2 + d1) times. The two counts appear on fire1_o and fire2_o after the step's edge.
- R6: A step leaves a - n1 - n2 in a, c - n1 + n2 in c, and c' - n2 + n1 in c'.
- R7: Every step fires n1 + n2 = min(a, c + c') rules in total and leaves c + c' unchanged. The host keeps c + c' within 16 bits.
- R8: A cycle with step_i and load_i both low leaves the populations, the firing outputs and the generator unchanged.
- R9: halted_o is high exactly when a is zero or c + c' is zero, which is when neither rule can fire.
- R10: Each transition completes in the one edge that samples step_i. With step_i held high, the populations change on every consecutive edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_i | input | 16 | Generator seed taken on load |
| load_i | input | 1 | Load initial populations and seed |
| init_a_i | input | 16 | Initial count of a |
| init_c_i | input | 16 | Initial count of c |
| init_cp_i | input | 16 | Initial count of c-prime |
| step_i | input | 1 | Perform one transition |
| cnt_a_o | output | 16 | Current count of a |
| cnt_c_o | output | 16 | Current count of c |
| cnt_cp_o | output | 16 | Current count of c-prime |
| fire1_o | output | 16 | Firings of the first rule in the last step |
| fire2_o | output | 16 | Firings of the second rule in the last step |
| halted_o | output | 1 | No rule can fire |

## Verification
Two functions can land in one cycle: the surplus handover from one rule and the partner cap of the other. Cases where a1 exceeds c while a2 stays under c', and the mirror case, make the handover and the cap act together in the same transition. These cases come from table rows with lopsided partner counts and from seeds that push the split to either end. The bench judges each step against a model built from the requirement formulas. It also checks that the total fired equals min(a, c + c') and that c + c' does not move. A load raised together with a step checks the other overlap: the load must win.

// File: rtl/rivalry_pkg.sv
package rivalry_pkg;

   // Feedback tap masks for maximal-length Fibonacci generators.
   function automatic logic [63:0] tap_mask(input int unsigned w);
      case (w)
         8:       tap_mask = 64'h0000_0000_0000_00B8;
         16:      tap_mask = 64'h0000_0000_0000_B400;
         32:      tap_mask = 64'h0000_0000_8020_0003;
         default: tap_mask = 64'h0;
      endcase
   endfunction

   function automatic bit width_supported(input int unsigned w);
      width_supported = (w == 8) || (w == 16) || (w == 32);
   endfunction

endpackage

// File: rtl/rivalry_lfsr.sv
module rivalry_lfsr
   import rivalry_pkg::*;
#(
   parameter int unsigned LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [LW-1:0] seed_i,
   input  logic          adv_i,
   output logic [LW-1:0] state_o
);
   localparam logic [63:0]   MASK64 = tap_mask(LW);
   localparam logic [LW-1:0] MASK   = MASK64[LW-1:0];
   localparam logic [LW-1:0] ONE    = LW'(1);

   logic [LW-1:0] state_q;
   logic          fb;

   generate
      if (!width_supported(LW)) begin : g_bad_width
         $error("rivalry_lfsr: LW must be 8, 16 or 32");
      end
   endgenerate

   assign fb = ^(state_q & MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ONE;
      end else if (load_i) begin
         state_q <= (seed_i == '0) ? ONE : seed_i;
      end else if (adv_i) begin
         state_q <= {state_q[LW-2:0], fb};
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/rivalry_split.sv
module rivalry_split #(
   parameter int unsigned CW = 16,
   parameter int unsigned LW = 16
) (
   input  logic [CW-1:0] a_i,
   input  logic [LW-1:0] rnd_i,
   output logic [CW-1:0] a1_o,
   output logic [CW-1:0] a2_o
);
   localparam int unsigned PW = CW + LW;

   logic [PW-1:0] prod;

   assign prod = {{LW{1'b0}}, a_i} * {{CW{1'b0}}, rnd_i};
   assign a1_o = prod[PW-1:LW];
   assign a2_o = a_i - a1_o;
endmodule

// File: rtl/rivalry_rule.sv
module rivalry_rule #(
   parameter int unsigned CW = 16
) (
   input  logic [CW-1:0] share_i,
   input  logic [CW-1:0] partner_i,
   input  logic [CW-1:0] rival_left_i,
   output logic [CW-1:0] left_o,
   output logic [CW-1:0] fire_o
);
   logic [CW:0] offer;

   // Surplus of this rule's own share, independent of the rival.
   assign left_o = (share_i > partner_i) ? (share_i - partner_i) : '0;

   assign offer  = {1'b0, share_i} + {1'b0, rival_left_i};
   assign fire_o = (offer > {1'b0, partner_i}) ? partner_i : offer[CW-1:0];
endmodule

// File: rtl/rivalry_step.sv
module rivalry_step #(
   parameter int unsigned CW = 16,
   parameter int unsigned LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] seed_i,
   input  logic          load_i,
   input  logic [CW-1:0] init_a_i,
   input  logic [CW-1:0] init_c_i,
   input  logic [CW-1:0] init_cp_i,
   input  logic          step_i,
   output logic [CW-1:0] cnt_a_o,
   output logic [CW-1:0] cnt_c_o,
   output logic [CW-1:0] cnt_cp_o,
   output logic [CW-1:0] fire1_o,
   output logic [CW-1:0] fire2_o,
   output logic          halted_o
);
   generate
      if (CW < 2) begin : g_bad_cw
         $error("rivalry_step: CW must be at least 2");
      end
   endgenerate

   logic [CW-1:0] a_q, c_q, cp_q, f1_q, f2_q;
   logic [LW-1:0] rnd;
   logic [CW-1:0] a1, a2;
   logic [CW-1:0] left1, left2;
   logic [CW-1:0] n1, n2;
   logic          adv;

   assign adv = step_i && !load_i;

   rivalry_lfsr #(.LW(LW)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .seed_i  (seed_i),
      .adv_i   (adv),
      .state_o (rnd)
   );

   rivalry_split #(.CW(CW), .LW(LW)) u_split (
      .a_i   (a_q),
      .rnd_i (rnd),
      .a1_o  (a1),
      .a2_o  (a2)
   );

   // Rule one: a + c -> c'.  Rule two: a + c' -> c.
   rivalry_rule #(.CW(CW)) u_rule1 (
      .share_i      (a1),
      .partner_i    (c_q),
      .rival_left_i (left2),
      .left_o       (left1),
      .fire_o       (n1)
   );

   rivalry_rule #(.CW(CW)) u_rule2 (
      .share_i      (a2),
      .partner_i    (cp_q),
      .rival_left_i (left1),
      .left_o       (left2),
      .fire_o       (n2)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q  <= '0;
         c_q  <= '0;
         cp_q <= '0;
         f1_q <= '0;
         f2_q <= '0;
      end else if (load_i) begin
         a_q  <= init_a_i;
         c_q  <= init_c_i;
         cp_q <= init_cp_i;
         f1_q <= '0;
         f2_q <= '0;
      end else if (step_i) begin
         a_q  <= a_q - n1 - n2;
         c_q  <= c_q - n1 + n2;
         cp_q <= cp_q - n2 + n1;
         f1_q <= n1;
         f2_q <= n2;
      end
   end

   assign cnt_a_o  = a_q;
   assign cnt_c_o  = c_q;
   assign cnt_cp_o = cp_q;
   assign fire1_o  = f1_q;
   assign fire2_o  = f2_q;
   assign halted_o = (n1 == '0) && (n2 == '0);
endmodule

// File: rtl/rivalry_step_chk.sv
module rivalry_step_chk #(
   parameter int unsigned CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          load_i,
   input logic [CW-1:0] init_a_i,
   input logic [CW-1:0] init_c_i,
   input logic [CW-1:0] init_cp_i,
   input logic          step_i,
   input logic [CW-1:0] cnt_a_o,
   input logic [CW-1:0] cnt_c_o,
   input logic [CW-1:0] cnt_cp_o,
   input logic [CW-1:0] fire1_o,
   input logic [CW-1:0] fire2_o,
   input logic          halted_o
);
   logic [CW:0] pool, drain, fired;

   assign pool  = {1'b0, cnt_c_o} + {1'b0, cnt_cp_o};
   assign drain = ({1'b0, cnt_a_o} < pool) ? {1'b0, cnt_a_o} : pool;
   assign fired = {1'b0, fire1_o} + {1'b0, fire2_o};

   a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_a_o == $past(init_a_i)) && (cnt_c_o == $past(init_c_i))
                 && (cnt_cp_o == $past(init_cp_i)) && (fire1_o == '0) && (fire2_o == '0));

   a_r5_fire_capped: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (fire1_o <= $past(cnt_c_o)) && (fire2_o <= $past(cnt_cp_o)));

   a_r7_total_fired: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (fired == $past(drain)));

   a_r7_pool_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (pool == $past(pool)));

   a_r6_a_drained: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> ({1'b0, cnt_a_o} == {1'b0, $past(cnt_a_o)} - $past(drain)));

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(cnt_a_o) && $stable(cnt_c_o) && $stable(cnt_cp_o)
                               && $stable(fire1_o) && $stable(fire2_o));

   a_r9_halt_flag: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o == ((cnt_a_o == '0) || (pool == '0)));
endmodule

bind rivalry_step rivalry_step_chk #(.CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_i    (load_i),
   .init_a_i  (init_a_i),
   .init_c_i  (init_c_i),
   .init_cp_i (init_cp_i),
   .step_i    (step_i),
   .cnt_a_o   (cnt_a_o),
   .cnt_c_o   (cnt_c_o),
   .cnt_cp_o  (cnt_cp_o),
   .fire1_o   (fire1_o),
   .fire2_o   (fire2_o),
   .halted_o  (halted_o)
);

// File: tb/sim_rivalry_step.sv
module sim_rivalry_step;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] seed_i = '0;
   logic        load_i = 1'b0;
   logic [15:0] init_a_i = '0, init_c_i = '0, init_cp_i = '0;
   logic        step_i = 1'b0;
   logic [15:0] cnt_a_o, cnt_c_o, cnt_cp_o, fire1_o, fire2_o;
   logic        halted_o;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   // model state
   longint ma, mc, mcp, ml, mn1, mn2;

   always #10 clk = ~clk;

   rivalry_step u0 (
      .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .load_i(load_i),
      .init_a_i(init_a_i), .init_c_i(init_c_i), .init_cp_i(init_cp_i),
      .step_i(step_i), .cnt_a_o(cnt_a_o), .cnt_c_o(cnt_c_o), .cnt_cp_o(cnt_cp_o),
      .fire1_o(fire1_o), .fire2_o(fire2_o), .halted_o(halted_o)
   );

   // {a, c, c', seed, a after first step}
   localparam logic [79:0] VEC [8] = '{
      {16'd100,   16'd30,    16'd50,    16'hACE1, 16'd20},
      {16'd40,    16'd100,   16'd100,   16'h1234, 16'd0},
      {16'd0,     16'd5,     16'd7,     16'h0001, 16'd0},
      {16'd25,    16'd0,     16'd0,     16'h0000, 16'd25},
      {16'd1000,  16'd0,     16'd600,   16'hFFFF, 16'd400},
      {16'd65535, 16'd20000, 16'd20000, 16'h8000, 16'd25535},
      {16'd7,     16'd7,     16'd0,     16'h00FF, 16'd0},
      {16'd500,   16'd250,   16'd250,   16'h5A5A, 16'd0}
   };

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint lmin(input longint x, input longint y);
      return (x < y) ? x : y;
   endfunction

   // One transition of the reference model, from R3..R6.
   task automatic model_step();
      longint a1, a2, d1, d2;
      a1  = (ma * ml) >> 16;
      a2  = ma - a1;
      d1  = (a1 > mc)  ? a1 - mc  : 0;
      d2  = (a2 > mcp) ? a2 - mcp : 0;
      mn1 = lmin(mc,  a1 + d2);
      mn2 = lmin(mcp, a2 + d1);
      ma  = ma - mn1 - mn2;
      mc  = mc - mn1 + mn2;
      mcp = mcp - mn2 + mn1;
      ml  = ((ml << 1) & 16'hFFFE) | (((ml >> 15) ^ (ml >> 13) ^ (ml >> 12) ^ (ml >> 10)) & 1);
   endtask

   task automatic do_load(input logic [15:0] a, input logic [15:0] c,
                          input logic [15:0] cp, input logic [15:0] sd);
      @(negedge clk);
      load_i = 1'b1; init_a_i = a; init_c_i = c; init_cp_i = cp; seed_i = sd;
      @(negedge clk);
      load_i = 1'b0;
      ma = a; mc = c; mcp = cp; ml = (sd == 0) ? 1 : sd;
   endtask

   task automatic check_all(input string tag);
      check({tag, " a"},  cnt_a_o,  ma);
      check({tag, " c"},  cnt_c_o,  mc);
      check({tag, " cp"}, cnt_cp_o, mcp);
      check({tag, " n1"}, fire1_o,  mn1);
      check({tag, " n2"}, fire2_o,  mn2);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 a",  cnt_a_o, 0);
      check("R1 c",  cnt_c_o, 0);
      check("R1 cp", cnt_cp_o, 0);
      check("R1 n1", fire1_o, 0);
      check("R1 halted", halted_o, 1);
      rst_n = 1'b1;

      // Table walk: load, then four back-to-back steps (R10).
      foreach (VEC[i]) begin
         do_load(VEC[i][79:64], VEC[i][63:48], VEC[i][47:32], VEC[i][31:16]);
         check("R2 a", cnt_a_o, ma);
         check("R2 c", cnt_c_o, mc);
         check("R2 cp", cnt_cp_o, mcp);
         check("R9 halted", halted_o, (ma == 0 || mc + mcp == 0) ? 1 : 0);
         step_i = 1'b1;
         for (int s = 0; s < 4; s++) begin
            longint pool;
            pool = mc + mcp;
            model_step();
            @(negedge clk);
            check_all("R3 R4 R5 R6 R10");
            check("R7 pool", longint'(cnt_c_o) + longint'(cnt_cp_o), pool);
            if (s == 0) check("R7 drain", cnt_a_o, VEC[i][15:0]);
            check("R9 halted", halted_o, (ma == 0 || mc + mcp == 0) ? 1 : 0);
         end
         step_i = 1'b0;
      end

      // R8: idle cycles change nothing, generator does not advance.
      do_load(16'd300, 16'd120, 16'd90, 16'h3C3C);
      repeat (3) @(negedge clk);
      check("R8 a", cnt_a_o, 300);
      check("R8 c", cnt_c_o, 120);
      check("R8 n1", fire1_o, 0);
      step_i = 1'b1;
      model_step();
      @(negedge clk);
      step_i = 1'b0;
      check_all("R8 R3 after idle");
      @(negedge clk);
      check("R8 hold a", cnt_a_o, ma);
      check("R8 hold n2", fire2_o, mn2);

      // R2: load wins over a step in the same cycle.
      @(negedge clk);
      load_i = 1'b1; step_i = 1'b1;
      init_a_i = 16'd77; init_c_i = 16'd11; init_cp_i = 16'd22; seed_i = 16'h0000;
      @(negedge clk);
      load_i = 1'b0; step_i = 1'b0;
      check("R2 prio a", cnt_a_o, 77);
      check("R2 prio c", cnt_c_o, 11);
      check("R2 prio n1", fire1_o, 0);
      check("R2 prio n2", fire2_o, 0);
      // zero seed became 1 (R3): next step follows the model from L=1
      ma = 77; mc = 11; mcp = 22; ml = 1;
      step_i = 1'b1;
      model_step();
      @(negedge clk);
      step_i = 1'b0;
      check_all("R2 R3 zero seed");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule